// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block generates all of the housekeeping traffic that an asynchronous DRAM needs on its own. Once reset is released it waits out the supply settling time. It then runs a fixed number of initialisation cycles, each with a RAS pulse. After that it paces CAS-before-RAS refreshes at a fixed interval, so that the device's internal row counter walks every row within the retention window. No row address is ever supplied, and the sequencer never drives the data pins.

The sequencer shares the DRAM strobes with an access controller through a request/grant pair. It raises `req_o` whenever it owes a cycle. It starts a cycle only on a clock where the grant is present. It keeps the request raised until the final precharge cycle has ended. Refresh slots that the controller cannot grant in time are counted, up to a saturating limit, and are replayed back to back once the grant comes. `init_done_o` tells the controller when normal accesses may begin.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high, `req_o` is 0, `ras_n_o` and `cas_n_o` are 1, `we_n_o` is 1 and `init_done_o` is 0.
- R2: For the first POWERUP_CYC-1 clocks after reset is released, `req_o` stays 0 and both strobes stay 1, even if the grant is asserted. `req_o` is 1 after the POWERUP_CYC-th clock.
- R3: After the power-up wait, exactly INIT_CYCLES strobe cycles are performed. `init_done_o` rises on the clock after the last precharge clock of the final one. Once set, it stays set until reset.
- R4: Every cycle has the same shape. `cas_n_o` is low (with `ras_n_o` high) for CAS_LEAD_CYC clocks. Then both are low for RAS_LOW_CYC clocks. Then both are high for PRECH_CYC clocks. RAS never falls unless CAS is already low.
- R5: `we_n_o` is 1 at all times, so that every cycle is decoded as a refresh.
- R6: A cycle starts (CAS falls) only on the clock after one where `req_o` and `gnt_i` were both 1. A grant without owed work produces no strobe.
- R7: After `init_done_o` rises, one refresh becomes owed every REFRESH_INT_CYC clocks. The first one is owed REFRESH_INT_CYC clocks after the rise.
- R8: Refreshes that are owed but not granted accumulate. `req_o` stays 1 until all of them have been performed. With the grant held, they run back to back, with one idle clock between cycles.
- R9: The owed count saturates at 2**PEND_W-1. Intervals that expire at the limit are dropped.
- R10: `req_o` stays 1 from a cycle's start through its last precharge clock. It falls on the next clock if nothing else is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt_i | input | 1 | Strobe ownership granted by the access controller |
| req_o | output | 1 | Sequencer owes or is running a cycle |
| ras_n_o | output | 1 | Row strobe to the DRAM, active low |
| cas_n_o | output | 1 | Column strobe to the DRAM, active low |
| we_n_o | output | 1 | Write enable to the DRAM, held high |
| init_done_o | output | 1 | Power-up and initialisation complete |

## Verification
A corrupted cycle-phase counter shows up at once on the strobe pins: a RAS or CAS edge moves by a clock, or RAS falls while CAS is high. A per-clock reference comparison catches this on the same clock. A wrong owed count shows up only later. It appears as a request that drops early or lingers after a backlog drains, or as a refresh count that differs from the saturated limit. The bench therefore withholds the grant over many intervals and then counts the RAS pulses during the drain. A bad interval timer moves the spacing of steady-state RAS pulses, and that spacing is measured directly.

// File: rtl/dram_rfs_pkg.sv
package dram_rfs_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP    = 3'd0,
        ST_IDLE     = 3'd1,
        ST_CAS_LEAD = 3'd2,
        ST_RAS_ACT  = 3'd3,
        ST_PRECH    = 3'd4
    } rfs_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobe_for(input rfs_state_e s);
        strobe_t r;
        r.ras_n = (s != ST_RAS_ACT);
        r.cas_n = !((s == ST_CAS_LEAD) || (s == ST_RAS_ACT));
        return r;
    endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int unsigned PERIOD = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;
    logic          last;

    assign last   = (cnt == CW'(PERIOD - 1));
    assign tick_o = en_i && last;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/rfs_pending_ctr.sv
module rfs_pending_ctr #(
    parameter int unsigned PEND_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic inc_i,
    input  logic dec_i,
    output logic owed_o
);
    localparam logic [PEND_W-1:0] MAX_OWED = {PEND_W{1'b1}};

    logic [PEND_W-1:0] owed;

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else begin
            unique case ({inc_i, dec_i})
                2'b10:   if (owed != MAX_OWED) owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign owed_o = (owed != '0);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (owed == MAX_OWED && inc_i && !dec_i) |=> owed == MAX_OWED);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        dec_i |-> owed != '0);

endmodule

// File: rtl/rfs_cycle_fsm.sv
module rfs_cycle_fsm
    import dram_rfs_pkg::*;
#(
    parameter int unsigned POWERUP_CYC  = 20000,
    parameter int unsigned INIT_CYCLES  = 8,
    parameter int unsigned CAS_LEAD_CYC = 1,
    parameter int unsigned RAS_LOW_CYC  = 5,
    parameter int unsigned PRECH_CYC    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic gnt_i,
    input  logic refresh_owed_i,
    output logic req_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic done_o,
    output logic init_done_o
);
    localparam int unsigned MAXT = max_of(max_of(POWERUP_CYC, CAS_LEAD_CYC),
                                          max_of(RAS_LOW_CYC, PRECH_CYC));
    localparam int unsigned CW   = (MAXT > 2) ? $clog2(MAXT) : 1;
    localparam int unsigned IW   = $clog2(INIT_CYCLES + 1);

    rfs_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [IW-1:0] init_left_q;
    logic          init_done_q;
    strobe_t       strb_q;
    logic          work;
    logic          phase_last;

    assign work = init_done_q ? refresh_owed_i : (init_left_q != '0);

    always_comb begin
        unique case (state_q)
            ST_PWRUP:    phase_last = (cnt_q == CW'(POWERUP_CYC - 1));
            ST_CAS_LEAD: phase_last = (cnt_q == CW'(CAS_LEAD_CYC - 1));
            ST_RAS_ACT:  phase_last = (cnt_q == CW'(RAS_LOW_CYC - 1));
            ST_PRECH:    phase_last = (cnt_q == CW'(PRECH_CYC - 1));
            default:     phase_last = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_PWRUP:    if (phase_last) state_d = ST_IDLE;
            ST_IDLE: begin
                cnt_d = '0;
                if (work && gnt_i) state_d = ST_CAS_LEAD;
            end
            ST_CAS_LEAD: if (phase_last) state_d = ST_RAS_ACT;
            ST_RAS_ACT:  if (phase_last) state_d = ST_PRECH;
            ST_PRECH:    if (phase_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (phase_last) cnt_d = '0;
    end

    assign done_o = (state_q == ST_PRECH) && phase_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_PWRUP;
            cnt_q       <= '0;
            init_left_q <= IW'(INIT_CYCLES);
            init_done_q <= 1'b0;
            strb_q      <= '{ras_n: 1'b1, cas_n: 1'b1};
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            strb_q  <= strobe_for(state_d);
            if (done_o && !init_done_q) begin
                init_left_q <= init_left_q - 1'b1;
                if (init_left_q == IW'(1)) init_done_q <= 1'b1;
            end
        end
    end

    assign req_o       = (state_q != ST_PWRUP) && (work || state_q != ST_IDLE);
    assign ras_n_o     = strb_q.ras_n;
    assign cas_n_o     = strb_q.cas_n;
    assign init_done_o = init_done_q;

    // R6
    cas_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n_o) |-> $past(gnt_i) && $past(req_o));

    // R3
    init_done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done_o |=> init_done_o);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int unsigned POWERUP_CYC     = 20000,
    parameter int unsigned INIT_CYCLES     = 8,
    parameter int unsigned REFRESH_INT_CYC = 1500,
    parameter int unsigned CAS_LEAD_CYC    = 1,
    parameter int unsigned RAS_LOW_CYC     = 5,
    parameter int unsigned PRECH_CYC       = 3,
    parameter int unsigned PEND_W          = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic gnt_i,
    output logic req_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic init_done_o
);
    logic tick;
    logic owed;
    logic cyc_done;

    rfs_interval_timer #(.PERIOD(REFRESH_INT_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en_i   (init_done_o),
        .tick_o (tick)
    );

    rfs_pending_ctr #(.PEND_W(PEND_W)) u_pending (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (tick),
        .dec_i  (cyc_done && init_done_o),
        .owed_o (owed)
    );

    rfs_cycle_fsm #(
        .POWERUP_CYC  (POWERUP_CYC),
        .INIT_CYCLES  (INIT_CYCLES),
        .CAS_LEAD_CYC (CAS_LEAD_CYC),
        .RAS_LOW_CYC  (RAS_LOW_CYC),
        .PRECH_CYC    (PRECH_CYC)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .gnt_i          (gnt_i),
        .refresh_owed_i (owed),
        .req_o          (req_o),
        .ras_n_o        (ras_n_o),
        .cas_n_o        (cas_n_o),
        .done_o         (cyc_done),
        .init_done_o    (init_done_o)
    );

    assign we_n_o = 1'b1;

    // R4
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        !ras_n_o |-> !cas_n_o);

    // R4
    ras_fall_after_cas_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n_o) |-> !$past(cas_n_o));

    // R10
    strobe_owned_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n_o || !cas_n_o) |-> req_o);

endmodule

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
    localparam int P    = 50;
    localparam int NI   = 8;
    localparam int REFI = 100;
    localparam int TC   = 1;
    localparam int TR   = 4;
    localparam int TP   = 3;
    localparam int PW   = 3;
    localparam int L    = TC + TR + TP;
    localparam int MAXO = (1 << PW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b0;
    logic req, ras_n, cas_n, we_n, init_done;

    always #5 clk = ~clk;

    dram_refresh_seq #(
        .POWERUP_CYC(P), .INIT_CYCLES(NI), .REFRESH_INT_CYC(REFI),
        .CAS_LEAD_CYC(TC), .RAS_LOW_CYC(TR), .PRECH_CYC(TP), .PEND_W(PW)
    ) u_dram_refresh_seq (
        .clk(clk), .rst(rst), .gnt_i(gnt), .req_o(req), .ras_n_o(ras_n),
        .cas_n_o(cas_n), .we_n_o(we_n), .init_done_o(init_done)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit cmp_en = 1'b0;

    // behavioural reference
    int m_pu, m_init_left, m_owed, m_tmr, m_pos, m_ticks;
    bit m_init_done, m_busy;

    function automatic bit m_work();
        return m_init_done ? (m_owed > 0) : (m_init_left > 0);
    endfunction

    always @(posedge clk) begin
        bit dn, st, tk;
        cyc++;
        if (rst) begin
            m_pu = 0; m_init_left = NI; m_owed = 0; m_tmr = 0;
            m_pos = 0; m_init_done = 0; m_busy = 0; m_ticks = 0;
        end else begin
            dn = m_busy && (m_pos == L - 1);
            st = (m_pu == P) && !m_busy && m_work() && gnt;
            tk = m_init_done && (m_tmr == REFI - 1);
            if (m_pu < P) m_pu++;
            if (tk) m_ticks++;
            if (!m_init_done) m_tmr = 0;
            else if (tk) m_tmr = 0;
            else m_tmr++;
            if (tk && !(dn && m_init_done)) begin
                if (m_owed < MAXO) m_owed++;
            end else if (!tk && dn && m_init_done) m_owed--;
            if (dn && !m_init_done) begin
                m_init_left--;
                if (m_init_left == 0) m_init_done = 1;
            end
            if (st) begin m_busy = 1; m_pos = 0; end
            else if (m_busy) begin
                if (m_pos == L - 1) m_busy = 0; else m_pos++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    int ras_falls = 0;
    bit prev_ras  = 1'b1;
    int last_fall = 0;

    always @(negedge clk) begin
        bit e_ras, e_cas, e_req;
        if (prev_ras && !ras_n) begin ras_falls++; last_fall = cyc; end
        prev_ras = ras_n;
        if (cmp_en && !rst) begin
            e_cas = !(m_busy && m_pos < TC + TR);
            e_ras = !(m_busy && m_pos >= TC && m_pos < TC + TR);
            e_req = (m_pu == P) && (m_work() || m_busy);
            chk(ras_n == e_ras, "R4 ras_n", ras_n, e_ras);
            chk(cas_n == e_cas, "R4 cas_n", cas_n, e_cas);
            chk(req == e_req, "R10 req", req, e_req);
            chk(we_n == 1'b1, "R5 we_n", we_n, 1);
            chk(init_done == m_init_done, "R3 init_done", init_done, m_init_done);
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        int f0, t0, t1, k0, owed0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req == 0, "R1 req", req, 0);
        chk(ras_n == 1 && cas_n == 1, "R1 strobes", {ras_n, cas_n}, 3);
        chk(we_n == 1, "R1 we_n", we_n, 1);
        chk(init_done == 0, "R1 init_done", init_done, 0);
        gnt = 1'b1; // R6: grant during power-up must do nothing
        rst = 1'b0;
        cmp_en = 1'b1;
        for (int i = 1; i < P; i++) begin
            @(negedge clk);
            chk(req == 0 && cas_n == 1, "R2 quiet power-up", {req, cas_n}, 1);
        end
        @(negedge clk);
        chk(req == 1, "R2 request after wait", req, 1);
        gnt = 1'b0;
        repeat (10) @(negedge clk);
        chk(cas_n == 1 && req == 1, "R6 no strobe without grant", {req, cas_n}, 3);
        gnt = 1'b1;
        for (int i = 0; i < 200 && !init_done; i++) @(negedge clk);
        chk(ras_falls == NI, "R3 init cycle count", ras_falls, NI);
        // irregular grant pattern
        for (int i = 0; i < 600; i++) begin
            gnt = (i % 3 == 0) || (i % 7 == 2);
            @(negedge clk);
        end
        // R7 steady-state spacing
        gnt = 1'b1;
        repeat (150) @(negedge clk);
        f0 = ras_falls;
        for (int i = 0; i < 300 && ras_falls == f0; i++) @(negedge clk);
        t0 = last_fall;
        f0 = ras_falls;
        for (int i = 0; i < 300 && ras_falls == f0; i++) @(negedge clk);
        t1 = last_fall;
        chk(t1 - t0 == REFI, "R7 refresh spacing", t1 - t0, REFI);
        // R8/R9 backlog with saturation
        gnt = 1'b0;
        repeat (10 * REFI) @(negedge clk);
        chk(req == 1, "R8 request held while owed", req, 1);
        owed0 = m_owed;
        chk(owed0 == MAXO, "R9 saturated backlog (reference)", owed0, MAXO);
        f0 = ras_falls;
        k0 = m_ticks;
        gnt = 1'b1;
        for (int i = 0; i < 300 && !(req == 0); i++) @(negedge clk);
        chk(ras_falls - f0 == owed0 + (m_ticks - k0), "R9 drained refresh count",
            ras_falls - f0, owed0 + (m_ticks - k0));
        chk(req == 0, "R8 request drops after drain", req, 0);
        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule